// File: doc/BRIEF.md
# Serial Flash SPI Master Controller

This block is a register-programmed SPI master intended for talking to a boot flash device. Firmware configures a command register with the word length, clock mode, transfer direction and chip-select choice. It loads up to four words into a transmit FIFO and then starts a block by writing a word count and a start bit. The controller shifts each word most significant bit first over the programmed length, between 1 and 32 bits. Received words land right-aligned in a four-entry receive FIFO.

The serial clock comes from the system clock through a fixed half-period divider (parameter `DIV_HALF`). Chip-select lines are driven purely under software control. When the last word of a block has been shifted, the controller drops busy, raises a ready flag and, if enabled, an interrupt. Ready and the FIFO error flags are cleared by writing ones to the status register.

Register offsets in bytes: command 0x00, status 0x04, block control 0x0C, transmit FIFO port 0x10 (write), receive FIFO port 0x20 (read). Bus reads return data on `bus_rdata` one clock after `bus_rd` is sampled.

Top module: `sflash_master`

## Requirements
- R1: After reset the status register reads 0x0280_0000 (only RX-empty bit 25 and TX-empty bit 23 set), `cs_n` is all ones, and `irq` and `sclk` are low.
- R2: A write to 0x0C with bit 31 set, while command bit 28 (master) is set and the block is idle, starts a block of (bits[15:0] + 1) words. Status bit 31 (busy) is set during the block. At its end busy clears, status bit 30 (ready) sets, and control bit 31 reads back 0.
- R3: A write to 0x10 while the TX FIFO holds four words is dropped and sets status bit 26 (overflow).
- R4: A read of 0x20 while the RX FIFO is empty returns zero and sets status bit 27 (underflow).
- R5: Writing a 1 to status bit 30, 27 or 26 clears that bit. Bits written as 0 are unchanged.
- R6: The word length is command bits[4:0] + 1. Bits [len-1:0] of each TX word are sent MSB first, and each received word is right-aligned with its upper bits zero.
- R7: Command bits[27:26] = 1 makes the idle clock high; any other value makes it low. Command bit 21 = 0 changes data on the trailing edge and samples on the leading edge. Bit 21 = 1 changes data on the leading edge and samples on the trailing edge. While not busy, `sclk` rests at the idle level.
- R8: With command bit 15 (TX enable) clear, zeros are sent and the full programmed number of words is still clocked. With command bit 14 (RX enable) clear, nothing enters the RX FIFO.
- R9: `irq` is high while ready is set and control bit 26 or bit 27 is set, and low otherwise.
- R10: When command bit 12 (software chip select) is set, each `cs_n[i]` whose enable bit (5+i) is set drives command bit 13, and every other line is high. When bit 12 is clear, all lines are high. The level holds between blocks until the command register is rewritten.
- R11: A start request is ignored while command bit 28 is clear.
- R12: Status bits 25/24 report RX empty/full and bits 23/22 report TX empty/full.
- R13: Writes to 0x0C while busy are ignored, including a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Block-complete interrupt, level |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines |

## Verification
Faults in the shift engine show up as wrong received words in loopback, or as a wrong count of serial clock rising edges, both visible as soon as a block ends. Faults in the FIFO pointers show up when a word is lost or repeated in the RX read-back order, or when the full and empty flags disagree with the number of words written. Faults in the flag logic show up in the next status read, or one cycle later on `irq`. A stuck busy or engine state is caught because the block never completes within the poll limit.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] A_CMD  = 7'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 7'h04;
  localparam logic [ADDR_W-1:0] A_CTRL = 7'h0C;
  localparam logic [ADDR_W-1:0] A_TXF  = 7'h10;
  localparam logic [ADDR_W-1:0] A_RXF  = 7'h20;

  // command fields
  localparam int C_CS_BASE = 5;
  localparam int C_SWCS    = 12;
  localparam int C_CSLVL   = 13;
  localparam int C_RXEN    = 14;
  localparam int C_TXEN    = 15;
  localparam int C_PHASE   = 21;
  localparam int C_MASTER  = 28;

  // status fields
  localparam int S_BUSY = 31;
  localparam int S_RDY  = 30;
  localparam int S_UNF  = 27;
  localparam int S_OVF  = 26;
  localparam int S_RXE  = 25;
  localparam int S_RXF  = 24;
  localparam int S_TXE  = 23;
  localparam int S_TXF  = 22;

  // control fields
  localparam int K_GO   = 31;
  localparam int K_IERX = 27;
  localparam int K_IETX = 26;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_RUN} eng_state_t;
endpackage

// File: rtl/sflash_fifo.sv
module sflash_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sflash_engine.sv
module sflash_engine
  import sflash_pkg::*;
#(
  parameter int W        = 32,
  parameter int CNT_W    = 16,
  parameter int DIV_HALF = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [CNT_W-1:0]     cnt_m1,
  input  logic [$clog2(W)-1:0] len_m1,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic                 tx_en,
  input  logic                 rx_en,
  input  logic [W-1:0]         tx_word,
  input  logic                 tx_empty,
  input  logic                 miso,
  output logic                 tx_pop,
  output logic                 rx_push,
  output logic [W-1:0]         rx_word,
  output logic                 done,
  output logic                 sclk,
  output logic                 mosi
);
  localparam int LEN_W  = $clog2(W);
  localparam int EDGE_W = LEN_W + 1;
  localparam int DIVW   = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  eng_state_t        state;
  logic [CNT_W-1:0]  left;
  logic [W-1:0]      sh, rxsh, rx_nx, ld_word, ld_align;
  logic [EDGE_W-1:0] edge_n;
  logic [DIVW-1:0]   div;
  logic              tick, leading, do_sample, do_shift, last_edge;

  assign tick      = (div == DIVW'(DIV_HALF-1));
  assign leading   = ~edge_n[0];
  assign do_sample = leading ^ cpha;
  assign do_shift  = ~(leading ^ cpha);
  assign last_edge = (edge_n == {len_m1, 1'b1});
  assign rx_nx     = do_sample ? {rxsh[W-2:0], miso} : rxsh;
  assign ld_word   = (tx_en && !tx_empty) ? tx_word : '0;
  assign ld_align  = ld_word << (W - 1 - int'(len_m1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      left    <= '0;
      sh      <= '0;
      rxsh    <= '0;
      edge_n  <= '0;
      div     <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      rx_word <= '0;
      done    <= 1'b0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      done    <= 1'b0;
      case (state)
        ENG_IDLE: begin
          sclk <= cpol;
          if (go) begin
            left  <= cnt_m1;
            state <= ENG_LOAD;
          end
        end
        ENG_LOAD: begin
          tx_pop <= tx_en && !tx_empty;
          if (!cpha) begin
            mosi <= ld_align[W-1];
            sh   <= ld_align << 1;
          end else begin
            sh   <= ld_align;
          end
          rxsh   <= '0;
          edge_n <= '0;
          div    <= '0;
          state  <= ENG_RUN;
        end
        default: begin
          if (tick) begin
            div  <= '0;
            sclk <= ~sclk;
            rxsh <= rx_nx;
            if (do_shift) begin
              mosi <= sh[W-1];
              sh   <= sh << 1;
            end
            if (last_edge) begin
              rx_push <= rx_en;
              rx_word <= rx_nx;
              if (left == '0) begin
                done  <= 1'b1;
                state <= ENG_IDLE;
              end else begin
                left  <= left - 1'b1;
                state <= ENG_LOAD;
              end
            end else begin
              edge_n <= edge_n + 1'b1;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sflash_master.sv
module sflash_master
  import sflash_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_CS     = 4,
  parameter int DIV_HALF   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int LEN_W = $clog2(BUS_W);

  logic [BUS_W-1:0] cmd_q, stat_v, ctrl_v, tx_head, rx_head, rx_word;
  logic [CNT_W-1:0] cnt_q;
  logic ie_tx, ie_rx, bsy_q, rdy_q, unf_q, ovf_q;
  logic wr_cmd, wr_stat, wr_ctrl, wr_tx, rd_rx, start;
  logic tx_push, tx_pop, tx_empty, tx_full;
  logic rx_push, rx_pop, rx_empty, rx_full, eng_done;

  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL) && !bsy_q;
  assign wr_tx   = bus_wr && (bus_addr == A_TXF);
  assign rd_rx   = bus_rd && (bus_addr == A_RXF);
  assign start   = wr_ctrl && bus_wdata[K_GO] && cmd_q[C_MASTER];
  assign tx_push = wr_tx && !tx_full;
  assign rx_pop  = rd_rx && !rx_empty;

  sflash_fifo #(.W(BUS_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
    .rdata(tx_head), .empty(tx_empty), .full(tx_full));

  sflash_fifo #(.W(BUS_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_head), .empty(rx_empty), .full(rx_full));

  sflash_engine #(.W(BUS_W), .CNT_W(CNT_W), .DIV_HALF(DIV_HALF)) u_eng (
    .clk(clk), .rst(rst), .go(start), .cnt_m1(bus_wdata[CNT_W-1:0]),
    .len_m1(cmd_q[LEN_W-1:0]), .cpol(cmd_q[27:26] == 2'b01),
    .cpha(cmd_q[C_PHASE]), .tx_en(cmd_q[C_TXEN]), .rx_en(cmd_q[C_RXEN]),
    .tx_word(tx_head), .tx_empty(tx_empty), .miso(miso), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word), .done(eng_done), .sclk(sclk),
    .mosi(mosi));

  always_comb begin
    stat_v         = '0;
    stat_v[S_BUSY] = bsy_q;
    stat_v[S_RDY]  = rdy_q;
    stat_v[S_UNF]  = unf_q;
    stat_v[S_OVF]  = ovf_q;
    stat_v[S_RXE]  = rx_empty;
    stat_v[S_RXF]  = rx_full;
    stat_v[S_TXE]  = tx_empty;
    stat_v[S_TXF]  = tx_full;
    ctrl_v          = '0;
    ctrl_v[K_GO]    = bsy_q;
    ctrl_v[K_IERX]  = ie_rx;
    ctrl_v[K_IETX]  = ie_tx;
    ctrl_v[CNT_W-1:0] = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      cnt_q     <= '0;
      ie_tx     <= 1'b0;
      ie_rx     <= 1'b0;
      bsy_q     <= 1'b0;
      rdy_q     <= 1'b0;
      unf_q     <= 1'b0;
      ovf_q     <= 1'b0;
      irq       <= 1'b0;
      cs_n      <= '1;
      bus_rdata <= '0;
    end else begin
      if (wr_cmd) cmd_q <= bus_wdata;
      if (wr_ctrl) begin
        cnt_q <= bus_wdata[CNT_W-1:0];
        ie_tx <= bus_wdata[K_IETX];
        ie_rx <= bus_wdata[K_IERX];
      end
      if (wr_stat) begin
        if (bus_wdata[S_RDY]) rdy_q <= 1'b0;
        if (bus_wdata[S_UNF]) unf_q <= 1'b0;
        if (bus_wdata[S_OVF]) ovf_q <= 1'b0;
      end
      if (wr_tx && tx_full)    ovf_q <= 1'b1;
      if (rd_rx && rx_empty)   unf_q <= 1'b1;
      if (start) begin
        bsy_q <= 1'b1;
        rdy_q <= 1'b0;
      end else if (eng_done) begin
        bsy_q <= 1'b0;
        rdy_q <= 1'b1;
      end
      irq <= rdy_q && (ie_tx || ie_rx);
      for (int i = 0; i < NUM_CS; i++)
        cs_n[i] <= (cmd_q[C_SWCS] && cmd_q[C_CS_BASE+i]) ? cmd_q[C_CSLVL] : 1'b1;
      if (bus_rd) begin
        case (bus_addr)
          A_CMD:   bus_rdata <= cmd_q;
          A_STAT:  bus_rdata <= stat_v;
          A_CTRL:  bus_rdata <= ctrl_v;
          A_RXF:   bus_rdata <= rx_empty ? '0 : rx_head;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sflash_master_chk.sv
module sflash_master_chk
  import sflash_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wgo,
  input logic              master,
  input logic              swcs,
  input logic              cpol,
  input logic              bsy,
  input logic              rdy,
  input logic              ovf,
  input logic              unf,
  input logic              tx_full,
  input logic              rx_empty,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n
);
  assert_busy_ready_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(bsy && rdy));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_TXF && tx_full) |=> ovf);

  assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_RXF && rx_empty) |=> unf);

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!bsy && $past(!bsy) && $stable(cpol)) |-> (sclk == cpol));

  assert_cs_released_R10: assert property (@(posedge clk) disable iff (rst)
    !swcs |=> (&cs_n));

  assert_no_start_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CTRL && wgo && !master && !bsy) |=> !bsy);
endmodule

bind sflash_master sflash_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .wgo(bus_wdata[31]), .master(cmd_q[28]), .swcs(cmd_q[12]),
  .cpol(cmd_q[27:26] == 2'b01), .bsy(bsy_q), .rdy(rdy_q), .ovf(ovf_q),
  .unf(unf_q), .tx_full(tx_full), .rx_empty(rx_empty), .sclk(sclk),
  .cs_n(cs_n));

// File: tb/sflash_master_test.sv
module sflash_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sclk, mosi, miso;
  logic [3:0]  cs_n;
  logic        loop_en = 1'b1, miso_fix = 1'b0;
  int          checks = 0, errors = 0, sclk_rises = 0, mosi_high = 0;
  bit          finished = 1'b0;

  localparam logic [31:0] M = 32'h1000_0000, SW = 32'h0000_1000, LVL = 32'h0000_2000;
  localparam logic [31:0] TXE = 32'h0000_8000, RXE = 32'h0000_4000, CS0 = 32'h0000_0020;
  localparam logic [31:0] PHA = 32'h0020_0000, POL = 32'h0400_0000, GO = 32'h8000_0000;
  localparam logic [31:0] IETX = 32'h0400_0000;

  always #2.5 clk = ~clk;
  assign miso = loop_en ? mosi : miso_fix;

  sflash_master uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always @(posedge sclk) sclk_rises++;
  always @(negedge clk) if (mosi) mosi_high++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    bit ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      rd(7'h04, s);
      if (!s[31]) begin ok = 1'b1; break; end
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=busy expected=idle", tag);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(7'h04, s);
    check("R1 status", s, 32'h0280_0000);
    check("R1 cs_n", {28'h0, cs_n}, 32'hF);
    check("R1 irq/sclk", {30'h0, irq, sclk}, 32'h0);
  endtask

  task automatic t_duplex_mode0();
    logic [31:0] d;
    loop_en = 1'b1;
    wr(7'h00, M | SW | CS0 | TXE | RXE | 32'd7);
    wr(7'h10, 32'hA5);
    wr(7'h10, 32'h3C);
    sclk_rises = 0;
    wr(7'h0C, GO | IETX | 32'd1);
    wr(7'h0C, GO | 32'd3);
    wait_done("R2 block end");
    check("R2 clock count", sclk_rises, 16);
    rd(7'h04, d);
    check("R2 ready set", d, 32'h4080_0000);
    check("R9 irq enabled", {31'h0, irq}, 32'h1);
    check("R10 cs0 active", {28'h0, cs_n}, 32'hE);
    rd(7'h0C, d);
    check("R13 ctrl unchanged", d, 32'h0400_0001);
    rd(7'h20, d);
    check("R6 word0", d, 32'hA5);
    rd(7'h20, d);
    check("R6 word1", d, 32'h3C);
    wr(7'h04, 32'h4000_0000);
    repeat (3) @(negedge clk);
    check("R9 irq after clear", {31'h0, irq}, 32'h0);
    rd(7'h04, d);
    check("R5 ready cleared", d, 32'h0280_0000);
  endtask

  task automatic t_mode3_len32();
    logic [31:0] d;
    wr(7'h00, M | SW | CS0 | TXE | RXE | PHA | POL | 32'd31);
    repeat (3) @(negedge clk);
    check("R7 idle high", {31'h0, sclk}, 32'h1);
    wr(7'h10, 32'hDEAD_BEEF);
    sclk_rises = 0;
    wr(7'h0C, GO);
    wait_done("R2 mode3 end");
    check("R6 32-bit clocks", sclk_rises, 32);
    check("R7 idle high after", {31'h0, sclk}, 32'h1);
    check("R9 irq disabled", {31'h0, irq}, 32'h0);
    rd(7'h20, d);
    check("R7 mode3 loopback", d, 32'hDEAD_BEEF);
    wr(7'h04, 32'h4000_0000);
  endtask

  task automatic t_mode1_len12();
    logic [31:0] d;
    wr(7'h00, M | SW | CS0 | TXE | RXE | PHA | 32'd11);
    wr(7'h10, 32'h0000_FABC);
    sclk_rises = 0;
    wr(7'h0C, GO);
    wait_done("R6 len12 end");
    check("R6 len12 clocks", sclk_rises, 12);
    rd(7'h20, d);
    check("R6 len12 masked", d, 32'h0000_0ABC);
    wr(7'h04, 32'h4000_0000);
  endtask

  task automatic t_rx_only();
    logic [31:0] d;
    loop_en = 1'b0; miso_fix = 1'b1;
    wr(7'h00, M | SW | CS0 | RXE | 32'd4);
    sclk_rises = 0; mosi_high = 0;
    wr(7'h0C, GO | 32'd1);
    wait_done("R8 rx-only end");
    check("R8 rx-only clocks", sclk_rises, 10);
    check("R8 zeros sent", mosi_high, 0);
    rd(7'h20, d);
    check("R8 rx word0", d, 32'h1F);
    rd(7'h20, d);
    check("R8 rx word1", d, 32'h1F);
    wr(7'h04, 32'h4000_0000);
    loop_en = 1'b1;
  endtask

  task automatic t_tx_only_underflow();
    logic [31:0] d;
    wr(7'h00, M | SW | CS0 | TXE | 32'd7);
    wr(7'h10, 32'h55);
    wr(7'h0C, GO);
    wait_done("R8 tx-only end");
    rd(7'h04, d);
    check("R8 rx untouched", d, 32'h4280_0000);
    rd(7'h20, d);
    check("R4 empty read zero", d, 32'h0);
    rd(7'h04, d);
    check("R4 underflow set", d, 32'h4A80_0000);
    wr(7'h04, 32'h4800_0000);
    rd(7'h04, d);
    check("R5 w1c ready+unf", d, 32'h0280_0000);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 1; i <= 5; i++) wr(7'h10, 32'(i));
    rd(7'h04, d);
    check("R3 overflow+R12 tx full", d, 32'h0640_0000);
    wr(7'h04, 32'h0400_0000);
    rd(7'h04, d);
    check("R5 overflow cleared", d, 32'h0240_0000);
    wr(7'h00, M | SW | CS0 | TXE | RXE | 32'd7);
    wr(7'h0C, GO | 32'd3);
    wait_done("R3 drain end");
    rd(7'h04, d);
    check("R12 rx full", d, 32'h4180_0000);
    for (int i = 1; i <= 4; i++) begin
      rd(7'h20, d);
      check("R3 kept word", d, 32'(i));
    end
    rd(7'h04, d);
    check("R3 fifth dropped", d, 32'h4280_0000);
    wr(7'h04, 32'h4000_0000);
  endtask

  task automatic t_chip_select();
    wr(7'h00, SW | 32'h0000_01E0);
    repeat (2) @(negedge clk);
    check("R10 all low", {28'h0, cs_n}, 32'h0);
    wr(7'h00, SW | LVL | 32'h0000_0080);
    repeat (2) @(negedge clk);
    check("R10 level high", {28'h0, cs_n}, 32'hF);
    wr(7'h00, SW | 32'h0000_0080);
    repeat (2) @(negedge clk);
    check("R10 cs2 only", {28'h0, cs_n}, 32'hB);
    wr(7'h00, 32'h0000_01E0);
    repeat (2) @(negedge clk);
    check("R10 sw off", {28'h0, cs_n}, 32'hF);
  endtask

  task automatic t_no_master();
    logic [31:0] d;
    wr(7'h00, SW | CS0 | TXE | RXE | 32'd7);
    sclk_rises = 0;
    wr(7'h0C, GO);
    repeat (20) @(negedge clk);
    rd(7'h04, d);
    check("R11 not started", d, 32'h0280_0000);
    check("R11 no clocks", sclk_rises, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_duplex_mode0();
    t_mode3_len32();
    t_mode1_len12();
    t_rx_only();
    t_tx_only_underflow();
    t_overflow();
    t_chip_select();
    t_no_master();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule